// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written over a register-style port into asynchronous serial frames on a single output line. A one-entry holding buffer sits in front of the shift register, so software can queue the next character while the current one is still going out. A separately staged ninth data bit supports 9-bit characters. Control fields select the character size (5 to 9 bits), the parity mode (none, even or odd) and one or two stop bits. An external single-cycle baud tick marks the bit boundaries.

Two interrupt requests are produced. One signals that the holding buffer can take another character. The other signals that the line has fallen silent with nothing left to send. Each request is gated by its own enable bit and by a global interrupt enable. When the transmitter is switched off, it keeps running until the buffer and the shift register are both empty. Only then does it give the line back to normal port control.

Top module: `sertx_tx`

## Requirements
- R1: After synchronous reset, every control field is zero. The line reads high, `line_own` is 0, `empty_flag` is 1, `done_flag` is 0 and both interrupt requests are 0, even with `glb_ie` set.
- R2: A frame is one low start bit, followed by the data bits LSB first, with each bit held for one tick interval. The size code gives the bit count: 000=5, 001=6, 010=7, 011=8, 111=9. The codes 100, 101 and 110 mean 8 bits. Data in the buffer reaches the shifter one clock after it is written whenever the shifter is idle.
- R3: Parity code 10 appends an even parity bit, which makes the count of ones in data plus parity even. Parity code 11 appends an odd parity bit. Codes 00 and 01 append no parity bit.
- R4: One stop bit (high) follows when `ctl_stop2`=0, and two follow when it is 1. The line stays high between frames.
- R5: The ninth data bit comes from a staging register written through `stage9_we`/`stage9_val`. A low-byte write latches the staged bit together with the byte, and later writes to the staging register do not alter the queued character.
- R6: A byte write is accepted only when the buffer is empty, and it clears `empty_flag`. A write while the buffer is full is ignored. When the shifter finishes a frame with the buffer full, the next start bit follows the last stop bit with no idle gap.
- R7: `line_own` is 1 while the transmitter is active. Byte writes while the enable bit is 0 are ignored, and the line stays high while the transmitter is inactive.
- R8: Clearing the enable bit while data is queued or shifting lets all pending frames finish. `line_own` drops exactly two clocks after the last stop-bit tick sample.
- R9: `done_flag` sets when the last stop bit ends with the buffer empty. It clears on a `done_clr` pulse or a `done_ack` pulse.
- R10: `irq_empty` is 1 exactly when the buffer-empty interrupt enable, `glb_ie` and `empty_flag` are all 1.
- R11: `irq_done` is 1 exactly when the complete interrupt enable, `glb_ie` and `done_flag` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| ctl_we | input | 1 | Writes all control fields below |
| ctl_en | input | 1 | Transmitter enable |
| ctl_size | input | 3 | Character size code |
| ctl_par | input | 2 | Parity mode |
| ctl_stop2 | input | 1 | Two stop bits when 1 |
| ctl_ie_empty | input | 1 | Buffer-empty interrupt enable |
| ctl_ie_done | input | 1 | Transmit-complete interrupt enable |
| glb_ie | input | 1 | Global interrupt enable |
| stage9_we | input | 1 | Writes the staged ninth bit |
| stage9_val | input | 1 | Ninth bit value |
| data_we | input | 1 | Low-byte write strobe |
| data_byte | input | 8 | Low data byte |
| done_clr | input | 1 | Write-one clear of the complete flag |
| done_ack | input | 1 | Interrupt acknowledge for the complete flag |
| txd | output | 1 | Serial output line |
| line_own | output | 1 | Transmitter owns the line |
| empty_flag | output | 1 | Buffer can take a byte |
| done_flag | output | 1 | Transmission complete |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Transmit-complete interrupt request |

## Verification
Framing is swept over all eight size codes, all four parity codes and both stop settings, with two data patterns each. This separates the size decode, the reserved-code fallback, the parity polarity and the stop count. Three queued writes, with the third landing on a full buffer, show that the handoff leaves no gap and that the overflow write is dropped. A staged ninth bit that is overwritten mid-frame shows that latching happens on the byte write. A disable that arrives while two characters are queued shows the drain and the exact cycle the line is released. All eight combinations of the two enables and the global enable are applied with both flags set, which isolates each term of the interrupt gating.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int MAX_DATA = 9;
    localparam int MAX_STOP = 2;
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + MAX_STOP;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_e;

    typedef struct packed {
        logic       en;
        logic [2:0] size;
        par_e       par;
        logic       stop2;
        logic       ie_empty;
        logic       ie_done;
    } cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic int data_len(input logic [2:0] code);
        case (code)
            3'b000:  return 5;
            3'b001:  return 6;
            3'b010:  return 7;
            3'b011:  return 8;
            3'b111:  return 9;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  cfg_t                cfg,
    input  logic [MAX_DATA-1:0] data,
    output frame_t              frame
);
    int   nbits;
    logic has_par;
    logic xsum;

    always_comb begin
        nbits   = data_len(cfg.size);
        has_par = (cfg.par == PAR_EVEN) || (cfg.par == PAR_ODD);
        xsum    = 1'b0;
        frame.bits    = '1;
        frame.bits[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < nbits) begin
                frame.bits[i + 1] = data[i];
                xsum = xsum ^ data[i];
            end
        end
        for (int j = 6; j <= MAX_DATA + 1; j++) begin
            if (has_par && (j == nbits + 1)) begin
                frame.bits[j] = (cfg.par == PAR_ODD) ? ~xsum : xsum;
            end
        end
        frame.len = LEN_W'(1 + nbits + (has_par ? 1 : 0) + (cfg.stop2 ? 2 : 1));
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  frame_t frame_in,
    output logic   busy,
    output logic   txd,
    output logic   frame_end
);
    logic [FRAME_W-1:0] sh_q;
    logic [LEN_W-1:0]   rem_q;

    assign frame_end = busy && tick && (rem_q == LEN_W'(1));
    assign txd       = busy ? sh_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            sh_q  <= '1;
            rem_q <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            sh_q  <= frame_in.bits;
            rem_q <= frame_in.len;
        end else if (busy && tick) begin
            if (rem_q == LEN_W'(1)) begin
                busy <= 1'b0;
            end else begin
                sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                rem_q <= rem_q - LEN_W'(1);
            end
        end
    end

    // R2: a load is followed by the low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (busy && !txd));

    // R2: without a tick the line level is held
    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !load) |=> $stable(txd));
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic buf_full,
    input  logic done_clr,
    input  logic done_ack,
    input  logic ie_empty,
    input  logic ie_done,
    input  logic gie,
    output logic empty_flag,
    output logic done_flag,
    output logic irq_empty,
    output logic irq_done
);
    logic set_done;

    assign set_done   = frame_end && !buf_full;
    assign empty_flag = !buf_full;
    assign irq_empty  = ie_empty && gie && empty_flag;
    assign irq_done   = ie_done && gie && done_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_flag <= 1'b0;
        end else if (set_done) begin
            done_flag <= 1'b1;
        end else if (done_clr || done_ack) begin
            done_flag <= 1'b0;
        end
    end

    // R9: a finished frame with nothing queued raises the flag
    assert_done_set_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !buf_full) |=> done_flag);

    // R9: either clear source drops the flag when no frame ends
    assert_done_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && (done_clr || done_ack)) |=> !done_flag);
endmodule

// File: rtl/sertx_tx.sv
module sertx_tx
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       ctl_we,
    input  logic       ctl_en,
    input  logic [2:0] ctl_size,
    input  logic [1:0] ctl_par,
    input  logic       ctl_stop2,
    input  logic       ctl_ie_empty,
    input  logic       ctl_ie_done,
    input  logic       glb_ie,
    input  logic       stage9_we,
    input  logic       stage9_val,
    input  logic       data_we,
    input  logic [7:0] data_byte,
    input  logic       done_clr,
    input  logic       done_ack,
    output logic       txd,
    output logic       line_own,
    output logic       empty_flag,
    output logic       done_flag,
    output logic       irq_empty,
    output logic       irq_done
);
    cfg_t                cfg_q;
    logic                stage9_q;
    logic [MAX_DATA-1:0] buf_q;
    logic                buf_full;
    logic                active;
    logic                busy;
    logic                frame_end;
    logic                load;
    logic                wr_ok;
    frame_t              frame;

    assign wr_ok    = data_we && cfg_q.en && !buf_full;
    assign load     = buf_full && (!busy || frame_end);
    assign line_own = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (ctl_we) begin
            cfg_q <= '{en: ctl_en, size: ctl_size, par: par_e'(ctl_par),
                       stop2: ctl_stop2, ie_empty: ctl_ie_empty, ie_done: ctl_ie_done};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage9_q <= 1'b0;
        end else if (stage9_we) begin
            stage9_q <= stage9_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full <= 1'b0;
            buf_q    <= '0;
        end else if (load) begin
            buf_full <= 1'b0;
        end else if (wr_ok) begin
            buf_full <= 1'b1;
            buf_q    <= {stage9_q, data_byte};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (cfg_q.en) begin
            active <= 1'b1;
        end else if (!buf_full && !busy) begin
            active <= 1'b0;
        end
    end

    sertx_framer u_framer (
        .cfg   (cfg_q),
        .data  (buf_q),
        .frame (frame)
    );

    sertx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .load      (load),
        .frame_in  (frame),
        .busy      (busy),
        .txd       (txd),
        .frame_end (frame_end)
    );

    sertx_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .buf_full   (buf_full),
        .done_clr   (done_clr),
        .done_ack   (done_ack),
        .ie_empty   (cfg_q.ie_empty),
        .ie_done    (cfg_q.ie_done),
        .gie        (glb_ie),
        .empty_flag (empty_flag),
        .done_flag  (done_flag),
        .irq_empty  (irq_empty),
        .irq_done   (irq_done)
    );

    // R7: an inactive transmitter leaves the line high
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
        !active |-> txd);

    // R7: writes while disabled never fill the buffer
    assert_ignore_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && !buf_full) |=> !buf_full);

    // R8: pending data keeps the transmitter active
    assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (active && (busy || buf_full)) |=> active);

    // R6: a write into a full buffer changes nothing
    assert_full_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (buf_full && data_we && !load) |=> (buf_full && $stable(buf_q)));

    // R5: the staged ninth bit is latched with the byte
    assert_latch9_R5: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (buf_q[MAX_DATA-1] == $past(stage9_q)));
endmodule

// File: tb/sertx_tx_tb_top.sv
module sertx_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick = 1'b0;
    logic       ctl_we, ctl_en, ctl_stop2, ctl_ie_empty, ctl_ie_done, glb_ie;
    logic [2:0] ctl_size;
    logic [1:0] ctl_par;
    logic       stage9_we, stage9_val, data_we, done_clr, done_ack;
    logic [7:0] data_byte;
    logic       txd, line_own, empty_flag, done_flag, irq_empty, irq_done;

    int errors = 0;
    int checks = 0;
    int tcnt = 0;

    logic       c_en = 1'b0, c_st2 = 1'b0, c_ieE = 1'b0, c_ieD = 1'b0;
    logic [2:0] c_size = 3'd3;
    logic [1:0] c_par = 2'd0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tcnt      <= (tcnt == 3) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == 3);
    end

    sertx_tx dut_i (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_size(ctl_size), .ctl_par(ctl_par),
        .ctl_stop2(ctl_stop2), .ctl_ie_empty(ctl_ie_empty), .ctl_ie_done(ctl_ie_done),
        .glb_ie(glb_ie), .stage9_we(stage9_we), .stage9_val(stage9_val),
        .data_we(data_we), .data_byte(data_byte), .done_clr(done_clr), .done_ack(done_ack),
        .txd(txd), .line_own(line_own), .empty_flag(empty_flag), .done_flag(done_flag),
        .irq_empty(irq_empty), .irq_done(irq_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic apply_ctl();
        @(negedge clk);
        ctl_en = c_en; ctl_size = c_size; ctl_par = c_par; ctl_stop2 = c_st2;
        ctl_ie_empty = c_ieE; ctl_ie_done = c_ieD; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic stage9(input logic v);
        @(negedge clk);
        stage9_we = 1'b1; stage9_val = v;
        @(negedge clk);
        stage9_we = 1'b0;
    endtask

    task automatic clear_done(input bit use_ack);
        @(negedge clk);
        if (use_ack) done_ack = 1'b1; else done_clr = 1'b1;
        @(negedge clk);
        done_ack = 1'b0; done_clr = 1'b0;
    endtask

    // expected frame from the requirement text, idle ones above the frame
    task automatic exp_frame(input logic [8:0] d, input logic [2:0] s, input logic [1:0] p,
                             input logic st2, output logic [63:0] e, output int len);
        int n, k, ones;
        n = (s <= 3'd3) ? 5 + int'(s) : ((s == 3'd7) ? 9 : 8);
        e = '1;
        e[0] = 1'b0;
        k = 1;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            e[k] = d[i];
            ones += int'(d[i]);
            k++;
        end
        if (p == 2'b10) begin
            e[k] = ((ones % 2) == 1);
            k++;
        end else if (p == 2'b11) begin
            e[k] = ((ones % 2) == 0);
            k++;
        end
        k += st2 ? 2 : 1;
        len = k;
    endtask

    task automatic stream(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          input int w0, input int w1, input int w2, input int dis_c,
                          input int s9_c, input int probe_c, input int want, input int cycles,
                          output logic [63:0] rec, output int rec_n, output logic [3:0] probe,
                          output int own_drop, output int last_c);
        logic started;
        started = 1'b0;
        rec = '1; rec_n = 0; probe = '0; own_drop = -1; last_c = -1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (!started && !txd) started = 1'b1;
            if (started && baud_tick && rec_n < 64) begin
                rec[rec_n] = txd;
                rec_n++;
                if (rec_n == want) last_c = c;
            end
            if (own_drop < 0 && !line_own) own_drop = c;
            if (c == probe_c) probe = {empty_flag, irq_empty, done_flag, irq_done};
            data_we   = (c == w0) || (c == w1) || (c == w2);
            data_byte = (c == w0) ? b0 : ((c == w1) ? b1 : b2);
            ctl_we    = (c == dis_c);
            if (c == dis_c) begin c_en = 1'b0; ctl_en = 1'b0; end
            stage9_we  = (c == s9_c);
            stage9_val = 1'b0;
        end
        @(negedge clk);
        data_we = 1'b0; ctl_we = 1'b0; stage9_we = 1'b0;
    endtask

    initial begin
        logic [63:0] rec, e1, e2, m;
        logic [3:0]  pr;
        int rn, len1, len2, od, lc, idx;
        logic [8:0]  d;

        rst = 1'b1;
        ctl_we = 0; ctl_en = 0; ctl_size = 0; ctl_par = 0; ctl_stop2 = 0;
        ctl_ie_empty = 0; ctl_ie_done = 0; glb_ie = 0;
        stage9_we = 0; stage9_val = 0; data_we = 0; data_byte = 0; done_clr = 0; done_ack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 line_own", line_own, 0);
        chk("R1 empty_flag", empty_flag, 1);
        chk("R1 done_flag", done_flag, 0);
        glb_ie = 1'b1;
        @(negedge clk);
        chk("R1 irqs with enables at reset", {irq_empty, irq_done}, 2'b00);

        // R7 write while disabled is ignored
        stream(8'h00, 8'h00, 8'h00, 0, -1, -1, -1, -1, -1, -1, 24, rec, rn, pr, od, lc);
        chk("R7 no frame while disabled", rec, '1);
        chk("R7 buffer untouched", {empty_flag, line_own}, 2'b10);

        c_en = 1'b1; c_size = 3'd3; c_par = 2'd0; c_st2 = 1'b0; c_ieE = 1'b1; c_ieD = 1'b1;
        apply_ctl();
        @(negedge clk);
        chk("R7 line_own when enabled", line_own, 1);

        // R2 R3 R4 R9: sweep every size, parity and stop setting
        idx = 0;
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int k = 0; k < 2; k++) begin
                        c_size = 3'(s); c_par = 2'(p); c_st2 = st[0];
                        apply_ctl();
                        d = 9'((idx * 37 + k * 157) ^ 9'h0AA);
                        stage9(d[8]);
                        exp_frame(d, c_size, c_par, c_st2, e1, len1);
                        stream(d[7:0], 8'h00, 8'h00, 0, -1, -1, -1, -1, -1, len1,
                               4 * (len1 + 4) + 8, rec, rn, pr, od, lc);
                        m = (64'd1 << (len1 + 2)) - 1;
                        chk($sformatf("R2/R3/R4 size=%0d par=%0d stop2=%0d data=%h", s, p, st, d),
                            rec & m, e1 & m);
                        chk("R9 done after frame", done_flag, 1);
                        clear_done(k[0]);
                        chk(k[0] ? "R9 cleared by ack" : "R9 cleared by write-one", done_flag, 0);
                        idx++;
                    end
                end
            end
        end

        // R10 R11 gating sweep with both flags set
        c_size = 3'd3; c_par = 2'd0; c_st2 = 1'b0;
        apply_ctl();
        stream(8'h81, 8'h00, 8'h00, 0, -1, -1, -1, -1, -1, -1, 60, rec, rn, pr, od, lc);
        chk("R9 flag set before gating sweep", {empty_flag, done_flag}, 2'b11);
        for (int g = 0; g < 8; g++) begin
            c_ieE = g[0]; c_ieD = g[1]; glb_ie = g[2];
            apply_ctl();
            chk($sformatf("R10 irq_empty combo=%0d", g), irq_empty, g[0] & g[2]);
            chk($sformatf("R11 irq_done combo=%0d", g), irq_done, g[1] & g[2]);
        end
        clear_done(1'b0);
        chk("R11 irq_done low after clear", irq_done, 0);

        // R6 handoff, overflow write and R10 with the buffer full
        stream(8'h55, 8'hC3, 8'hFF, 0, 2, 3, -1, -1, 3, -1, 4 * 24 + 8, rec, rn, pr, od, lc);
        exp_frame(9'h055, 3'd3, 2'd0, 1'b0, e1, len1);
        exp_frame(9'h0C3, 3'd3, 2'd0, 1'b0, e2, len2);
        m = (64'd1 << (len1 + len2 + 2)) - 1;
        chk("R6 two frames back to back, third write dropped",
            rec & m, ((e1 & ((64'd1 << len1) - 1)) | (e2 << len1)) & m);
        chk("R10 flags while buffer full", pr[3:2], 2'b00);
        chk("R6 empty after drain", empty_flag, 1);
        clear_done(1'b1);

        // R5 staged ninth bit latched at byte write
        c_size = 3'd7;
        apply_ctl();
        stage9(1'b1);
        stream(8'h00, 8'h00, 8'h00, 0, -1, -1, -1, 6, -1, -1, 4 * 15 + 8, rec, rn, pr, od, lc);
        exp_frame(9'h100, 3'd7, 2'd0, 1'b0, e1, len1);
        m = (64'd1 << (len1 + 2)) - 1;
        chk("R5 ninth bit kept after restage", rec & m, e1 & m);
        stream(8'h00, 8'h00, 8'h00, 0, -1, -1, -1, -1, -1, -1, 4 * 15 + 8, rec, rn, pr, od, lc);
        exp_frame(9'h000, 3'd7, 2'd0, 1'b0, e1, len1);
        chk("R5 restaged zero used by next write", rec & m, e1 & m);
        clear_done(1'b0);

        // R8 deferred disable
        c_size = 3'd3;
        apply_ctl();
        stream(8'hA7, 8'h3E, 8'h00, 0, 2, -1, 4, -1, -1, 20, 4 * 26 + 8, rec, rn, pr, od, lc);
        exp_frame(9'h0A7, 3'd3, 2'd0, 1'b0, e1, len1);
        exp_frame(9'h03E, 3'd3, 2'd0, 1'b0, e2, len2);
        m = (64'd1 << (len1 + len2 + 2)) - 1;
        chk("R8 queued frames finish after disable",
            rec & m, ((e1 & ((64'd1 << len1) - 1)) | (e2 << len1)) & m);
        chk("R8 line released two clocks after last stop", 64'(od), 64'(lc + 2));
        stream(8'h12, 8'h00, 8'h00, 0, -1, -1, -1, -1, -1, -1, 24, rec, rn, pr, od, lc);
        chk("R7 write after drain ignored", rec, '1);
        chk("R7 state after drain", {empty_flag, line_own, txd}, 3'b101);

        summary();
        $finish;
    end
endmodule